// File: doc/BRIEF.md
# Atomic Swap Memory Responder

This block is a byte-addressable memory endpoint that sits at the bottom of a memory hierarchy. It serves plain reads and writes and two atomic read-modify-write commands. An unconditional swap returns the old bytes and stores the new ones. A conditional swap returns the old bytes and stores the new ones only when the old bytes equal a supplied compare value. Each request names a command, a byte address, an access size of 1, 2, 4 or 8 bytes (naturally aligned), write data, a compare value, a needs-response flag and a flag saying that a cache has already answered it. Data sits little-endian on a 64-bit bus and is right-justified: an access of N bytes uses bits [8N-1:0] of the write data and returns its result in those bits, zero-extended.

Some requests need no work at the memory and are filtered out. These are requests already answered by a cache, clean evictions and clean writebacks. Cache maintenance (invalidate or clean) leaves the storage alone and is acknowledged only when asked. Both channels use valid/ready. An accepted request gives its response in the cycle after acceptance, from a single response register. The storage is a word-wide array whose depth is a parameter.

Top module: `swap_mem_responder`

## Requirements
- R1: A read (command 0) with the needs-response flag returns, one cycle after acceptance, the addressed bytes zero-extended and right-justified in little-endian order, with the error flag low.
- R2: A write (command 1) changes only the bytes covered by its address and size (size code 0..3 means 1, 2, 4, 8 bytes). If a response is requested, it carries data 0 and no error.
- R3: A swap (command 2) returns the old contents of the addressed bytes and always stores the request's write data there.
- R4: A conditional swap (command 3) returns the old contents. It stores the write data only when the old bytes equal the compare value. For a 4-byte access only the low 32 bits of the compare value take part.
- R5: A conditional swap with size code 0 or 1 leaves memory unchanged. It always produces a response with the error flag set and data 0.
- R6: A request with the cache-answered flag set causes no memory change and no response, whatever its command.
- R7: Clean-eviction (command 4) and clean-writeback (command 5) requests cause no memory change and no response.
- R8: A maintenance request (command 6) leaves memory unchanged. It produces an error-free response with data 0 only when the needs-response flag is set.
- R9: Reads, writes and swaps without the needs-response flag produce no response, but writes and swaps still update memory.
- R10: Command 7 is unrecognised. It leaves memory unchanged and always produces a response with the error flag set and data 0.
- R11: While a response is held with rsp_ready low, req_ready is low and rsp_valid, rsp_data and rsp_err stay stable.
- R12: After reset, rsp_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_cmd | input | 3 | Command code (0 read, 1 write, 2 swap, 3 conditional swap, 4 clean evict, 5 clean writeback, 6 maintenance, 7 unrecognised) |
| req_addr | input | $clog2(DEPTH)+3 | Byte address |
| req_size | input | 2 | Size code: log2 of the byte count |
| req_wdata | input | 64 | Write data, right-justified |
| req_cmp | input | 64 | Compare value for the conditional swap |
| req_need_rsp | input | 1 | Requester wants a response |
| req_cache_answered | input | 1 | A cache has already answered; drop the request |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 64 | Old or read data, right-justified, zero-extended |
| rsp_err | output | 1 | Illegal command or illegal conditional-swap size |

## Verification
The in-RTL checks assume that every accepted address is aligned to its own size. An assertion flags a violation as a broken input contract rather than a design fault. The stimulus keeps within this contract: it steps every sweep address in units of the access size. The checks also assume a held request keeps its fields until accepted. The back-pressure test changes the pending request only while req_ready is low, so nothing is accepted before the consumer frees the response register.

// File: rtl/swpmem_pkg.sv
package swpmem_pkg;

    localparam int DATA_W = 64;
    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [2:0] {
        CMD_READ    = 3'd0,
        CMD_WRITE   = 3'd1,
        CMD_SWAP    = 3'd2,
        CMD_CSWAP   = 3'd3,
        CMD_EVICT   = 3'd4,
        CMD_WBCLEAN = 3'd5,
        CMD_MAINT   = 3'd6,
        CMD_BAD     = 3'd7
    } cmd_e;

    typedef struct packed {
        logic do_write;     // store merged bytes
        logic conditional;  // store only on compare match
        logic ret_old;      // response carries old bytes
        logic respond;      // produce a response
        logic err;          // response flags an error
    } action_t;

    // Lanes touched by an access of 2**size bytes at byte offset off.
    function automatic logic [LANES-1:0] lane_mask(logic [1:0] size, logic [OFF_W-1:0] off);
        logic [LANES-1:0] base;
        case (size)
            2'd0:    base = LANES'(8'h01);
            2'd1:    base = LANES'(8'h03);
            2'd2:    base = LANES'(8'h0F);
            default: base = LANES'(8'hFF);
        endcase
        return base << off;
    endfunction

    // Bit mask of a right-justified value of 2**size bytes.
    function automatic logic [DATA_W-1:0] value_mask(logic [1:0] size);
        case (size)
            2'd0:    return DATA_W'(64'h0000_0000_0000_00FF);
            2'd1:    return DATA_W'(64'h0000_0000_0000_FFFF);
            2'd2:    return DATA_W'(64'h0000_0000_FFFF_FFFF);
            default: return {DATA_W{1'b1}};
        endcase
    endfunction

    function automatic logic size_aligned(logic [1:0] size, logic [OFF_W-1:0] off);
        logic [OFF_W-1:0] low;
        low = OFF_W'((1 << size) - 1);
        return (off & low) == '0;
    endfunction

endpackage

// File: rtl/swpmem_decode.sv
module swpmem_decode
    import swpmem_pkg::*;
(
    input  logic [2:0] cmd,
    input  logic [1:0] size,
    input  logic       need_rsp,
    input  logic       cache_answered,
    output action_t    act
);

    logic cswap_size_ok;

    always_comb begin
        cswap_size_ok = (size == 2'd2) || (size == 2'd3);
        act = '0;
        if (!cache_answered) begin
            case (cmd_e'(cmd))
                CMD_READ: begin
                    act.ret_old = 1'b1;
                    act.respond = need_rsp;
                end
                CMD_WRITE: begin
                    act.do_write = 1'b1;
                    act.respond  = need_rsp;
                end
                CMD_SWAP: begin
                    act.do_write = 1'b1;
                    act.ret_old  = 1'b1;
                    act.respond  = need_rsp;
                end
                CMD_CSWAP: begin
                    if (cswap_size_ok) begin
                        act.do_write    = 1'b1;
                        act.conditional = 1'b1;
                        act.ret_old     = 1'b1;
                        act.respond     = need_rsp;
                    end else begin
                        act.err     = 1'b1;
                        act.respond = 1'b1;
                    end
                end
                CMD_EVICT, CMD_WBCLEAN: begin
                    act = '0;
                end
                CMD_MAINT: begin
                    act.respond = need_rsp;
                end
                default: begin
                    act.err     = 1'b1;
                    act.respond = 1'b1;
                end
            endcase
        end
    end

    // An error action never stores anything.
    always_comb begin
        if (act.err) begin
            assert_err_no_store_R10: assert (!act.do_write);
        end
    end

endmodule

// File: rtl/swpmem_lane.sv
module swpmem_lane
    import swpmem_pkg::*;
(
    input  logic [DATA_W-1:0] cur_word,
    input  logic [OFF_W-1:0]  off,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] new_bytes,
    input  logic [DATA_W-1:0] cmp_val,
    output logic [DATA_W-1:0] old_val,
    output logic [DATA_W-1:0] merged,
    output logic              match
);

    logic [LANES-1:0]  bmask;
    logic [DATA_W-1:0] vmask;
    logic [DATA_W-1:0] shifted;
    logic [OFF_W+2:0]  shamt;

    always_comb begin
        shamt   = {off, 3'b000};
        vmask   = value_mask(size);
        bmask   = lane_mask(size, off);
        shifted = new_bytes << shamt;
        old_val = (cur_word >> shamt) & vmask;
        match   = (old_val == (cmp_val & vmask));
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[8*g +: 8] = bmask[g] ? shifted[8*g +: 8] : cur_word[8*g +: 8];
    end

endmodule

// File: rtl/swpmem_store.sv
module swpmem_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[widx] <= wdata;
        end
    end

    assign rdata = cells[ridx];

endmodule

// File: rtl/swap_mem_responder.sv
module swap_mem_responder
    import swpmem_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int AW    = IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_cmd,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] req_cmp,
    input  logic              req_need_rsp,
    input  logic              req_cache_answered,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err
);

    action_t           act;
    logic              accept;
    logic [IDX_W-1:0]  widx;
    logic [OFF_W-1:0]  off;
    logic [DATA_W-1:0] cur_word;
    logic [DATA_W-1:0] old_val;
    logic [DATA_W-1:0] merged;
    logic              match;
    logic              mem_we;

    assign widx   = req_addr[AW-1:OFF_W];
    assign off    = req_addr[OFF_W-1:0];
    assign req_ready = !rsp_valid || rsp_ready;
    assign accept = req_valid && req_ready;

    swpmem_decode u_decode (
        .cmd            (req_cmd),
        .size           (req_size),
        .need_rsp       (req_need_rsp),
        .cache_answered (req_cache_answered),
        .act            (act)
    );

    swpmem_store #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .widx  (widx),
        .wdata (merged),
        .ridx  (widx),
        .rdata (cur_word)
    );

    swpmem_lane u_lane (
        .cur_word  (cur_word),
        .off       (off),
        .size      (req_size),
        .new_bytes (req_wdata),
        .cmp_val   (req_cmp),
        .old_val   (old_val),
        .merged    (merged),
        .match     (match)
    );

    assign mem_we = accept && act.do_write && (!act.conditional || match);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_err   <= 1'b0;
        end else begin
            if (rsp_valid && rsp_ready) begin
                rsp_valid <= 1'b0;
            end
            if (accept && act.respond) begin
                rsp_valid <= 1'b1;
                rsp_data  <= act.ret_old ? old_val : '0;
                rsp_err   <= act.err;
            end
        end
    end

    // Input contract: accepted accesses are naturally aligned.
    assert_aligned_req_R2: assert property (@(posedge clk) disable iff (rst)
        accept |-> size_aligned(req_size, off));

    assert_read_resp_R1: assert property (@(posedge clk) disable iff (rst)
        accept && !req_cache_answered && req_cmd == CMD_READ && req_need_rsp
        |=> rsp_valid && !rsp_err);

    assert_write_ack_R2: assert property (@(posedge clk) disable iff (rst)
        accept && !req_cache_answered && req_cmd == CMD_WRITE && req_need_rsp
        |=> rsp_valid && rsp_data == '0 && !rsp_err);

    assert_swap_stores_R3: assert property (@(posedge clk) disable iff (rst)
        accept && !req_cache_answered && req_cmd == CMD_SWAP |-> mem_we);

    assert_cswap_size_R5: assert property (@(posedge clk) disable iff (rst)
        accept && !req_cache_answered && req_cmd == CMD_CSWAP && req_size < 2'd2
        |=> rsp_valid && rsp_err && rsp_data == '0);

    assert_cswap_nostore_R5: assert property (@(posedge clk) disable iff (rst)
        accept && !req_cache_answered && req_cmd == CMD_CSWAP && req_size < 2'd2
        |-> !mem_we);

    assert_cache_drop_R6: assert property (@(posedge clk) disable iff (rst)
        accept && req_cache_answered |=> !rsp_valid);

    assert_cache_nostore_R6: assert property (@(posedge clk) disable iff (rst)
        accept && req_cache_answered |-> !mem_we);

    assert_evict_silent_R7: assert property (@(posedge clk) disable iff (rst)
        accept && (req_cmd == CMD_EVICT || req_cmd == CMD_WBCLEAN) |=> !rsp_valid);

    assert_maint_resp_R8: assert property (@(posedge clk) disable iff (rst)
        accept && !req_cache_answered && req_cmd == CMD_MAINT
        |=> rsp_valid == $past(req_need_rsp) && !rsp_err);

    assert_need_flag_R9: assert property (@(posedge clk) disable iff (rst)
        accept && !req_need_rsp && req_cmd <= CMD_SWAP |=> !rsp_valid);

    assert_bad_cmd_R10: assert property (@(posedge clk) disable iff (rst)
        accept && !req_cache_answered && req_cmd == CMD_BAD
        |=> rsp_valid && rsp_err && rsp_data == '0);

    assert_ready_block_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |-> !req_ready);

    assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err));

endmodule

// File: tb/sim_swap_mem_responder.sv
`timescale 1ns/1ps
module sim_swap_mem_responder;

    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH) + 3;
    localparam int NB    = DEPTH * 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_cmd = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]  req_size = 2'd0;
    logic [63:0] req_wdata = '0;
    logic [63:0] req_cmp = '0;
    logic        req_need_rsp = 1'b0;
    logic        req_cache_answered = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [63:0] rsp_data;
    logic        rsp_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] mem [NB];

    always #10 clk = ~clk;

    swap_mem_responder #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .req_cmp(req_cmp),
        .req_need_rsp(req_need_rsp), .req_cache_answered(req_cache_answered),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .rsp_err(rsp_err)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (ok !== 1'b1) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mrd(input int a, input int s);
        logic [63:0] v = '0;
        for (int i = 0; i < (1 << s); i++) v[8*i +: 8] = mem[a + i];
        return v;
    endfunction

    task automatic mwr(input int a, input int s, input logic [63:0] v);
        for (int i = 0; i < (1 << s); i++) mem[a + i] = v[8*i +: 8];
    endtask

    task automatic issue(input logic [2:0] c, input int a, input int s,
                         input logic [63:0] wd, input logic [63:0] cv,
                         input logic nr, input logic ca,
                         output logic v, output logic [63:0] d, output logic e);
        @(negedge clk);
        req_cmd = c; req_addr = a[AW-1:0]; req_size = s[1:0];
        req_wdata = wd; req_cmp = cv; req_need_rsp = nr; req_cache_answered = ca;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        v = rsp_valid; d = rsp_data; e = rsp_err;
    endtask

    task automatic check_word(input int a, input string tag);
        logic v; logic [63:0] d; logic e;
        issue(3'd0, a & ~7, 3, '0, '0, 1'b1, 1'b0, v, d, e);
        chk(v && !e && d == mrd(a & ~7, 3), tag, d, mrd(a & ~7, 3));
    endtask

    function automatic logic [63:0] pat(input int k);
        logic [63:0] v;
        for (int b = 0; b < 8; b++) v[8*b +: 8] = 8'((k * 8 + b) * 37 + 5);
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic v; logic [63:0] d; logic e; logic [63:0] old, nv;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12: reset state
        chk(!rsp_valid, "R12 rsp_valid after reset", 64'(rsp_valid), 0);
        chk(req_ready, "R12 req_ready after reset", 64'(req_ready), 1);

        // R2: fill all words with 8-byte writes
        for (int w = 0; w < DEPTH; w++) begin
            issue(3'd1, w * 8, 3, pat(w), '0, 1'b1, 1'b0, v, d, e);
            chk(v && !e && d == 0, "R2 write ack", d, 0);
            mwr(w * 8, 3, pat(w));
        end

        // R1: read sweep, every size and aligned address
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < NB; a += (1 << s)) begin
                issue(3'd0, a, s, '0, '0, 1'b1, 1'b0, v, d, e);
                chk(v && !e && d == mrd(a, s), "R1 read", d, mrd(a, s));
            end

        // R2: partial writes at every aligned offset of word 5
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 8; o += (1 << s)) begin
                nv = 64'hA1B2_C3D4_E5F6_0718 ^ 64'(s * 97 + o);
                issue(3'd1, 40 + o, s, nv, '0, 1'b1, 1'b0, v, d, e);
                mwr(40 + o, s, nv);
                check_word(40, "R2 partial write");
            end

        // R3: unconditional swaps
        for (int s = 0; s < 4; s++) begin
            old = mrd(56, s);
            nv = 64'h0F1E_2D3C_4B5A_6978 + 64'(s);
            issue(3'd2, 56, s, nv, '0, 1'b1, 1'b0, v, d, e);
            chk(v && !e && d == old, "R3 swap old", d, old);
            mwr(56, s, nv);
            check_word(56, "R3 swap store");
        end

        // R4: conditional swap, 8 bytes, equal then unequal
        old = mrd(64, 3);
        issue(3'd3, 64, 3, 64'h1111_2222_3333_4444, old, 1'b1, 1'b0, v, d, e);
        chk(v && !e && d == old, "R4 cswap8 eq old", d, old);
        mwr(64, 3, 64'h1111_2222_3333_4444);
        check_word(64, "R4 cswap8 eq store");
        old = mrd(64, 3);
        issue(3'd3, 64, 3, 64'hDEAD_BEEF_0000_0001, old ^ 64'h1, 1'b1, 1'b0, v, d, e);
        chk(v && !e && d == old, "R4 cswap8 ne old", d, old);
        check_word(64, "R4 cswap8 ne unchanged");
        // R4: 4-byte compare uses only low 32 bits of the compare value
        old = mrd(76, 2);
        issue(3'd3, 76, 2, 64'h0000_0000_CAFE_F00D, {32'hFFFF_FFFF, old[31:0]}, 1'b1, 1'b0, v, d, e);
        chk(v && !e && d == old, "R4 cswap4 eq old", d, old);
        mwr(76, 2, 64'hCAFE_F00D);
        check_word(72, "R4 cswap4 eq store");
        old = mrd(72, 2);
        issue(3'd3, 72, 2, 64'h0000_0000_1234_5678, {old[31:0], old[31:0] ^ 32'h8000_0000}, 1'b1, 1'b0, v, d, e);
        chk(v && !e && d == old, "R4 cswap4 ne old", d, old);
        check_word(72, "R4 cswap4 ne unchanged");

        // R5: illegal conditional swap sizes
        for (int s = 0; s < 2; s++) begin
            issue(3'd3, 80, s, 64'hFF, mrd(80, s), 1'b0, 1'b0, v, d, e);
            chk(v && e && d == 0, "R5 cswap bad size err", {d[62:0], e}, 1);
            check_word(80, "R5 cswap bad size unchanged");
        end

        // R6: cache-answered requests are dropped
        issue(3'd1, 88, 3, 64'h5555_5555_5555_5555, '0, 1'b1, 1'b1, v, d, e);
        chk(!v, "R6 cache write no rsp", 64'(v), 0);
        check_word(88, "R6 cache write unchanged");
        issue(3'd7, 88, 3, '0, '0, 1'b1, 1'b1, v, d, e);
        chk(!v, "R6 cache bad cmd no rsp", 64'(v), 0);
        issue(3'd2, 88, 3, 64'h77, '0, 1'b1, 1'b1, v, d, e);
        chk(!v, "R6 cache swap no rsp", 64'(v), 0);
        check_word(88, "R6 cache swap unchanged");

        // R7: clean eviction and clean writeback
        for (int c = 4; c < 6; c++) begin
            issue(3'(c), 96, 3, 64'h9999_9999_9999_9999, '0, 1'b1, 1'b0, v, d, e);
            chk(!v, "R7 evict no rsp", 64'(v), 0);
            check_word(96, "R7 evict unchanged");
        end

        // R8: maintenance
        issue(3'd6, 96, 3, 64'h1, '0, 1'b1, 1'b0, v, d, e);
        chk(v && !e && d == 0, "R8 maint rsp", d, 0);
        issue(3'd6, 96, 3, 64'h1, '0, 1'b0, 1'b0, v, d, e);
        chk(!v, "R8 maint no rsp", 64'(v), 0);
        check_word(96, "R8 maint unchanged");

        // R9: no response without the flag, stores still happen
        issue(3'd0, 104, 3, '0, '0, 1'b0, 1'b0, v, d, e);
        chk(!v, "R9 read silent", 64'(v), 0);
        issue(3'd1, 104, 1, 64'hBEEF, '0, 1'b0, 1'b0, v, d, e);
        chk(!v, "R9 write silent", 64'(v), 0);
        mwr(104, 1, 64'hBEEF);
        check_word(104, "R9 silent write stored");
        issue(3'd2, 108, 2, 64'h0BAD_CAFE, '0, 1'b0, 1'b0, v, d, e);
        chk(!v, "R9 swap silent", 64'(v), 0);
        mwr(108, 2, 64'h0BAD_CAFE);
        check_word(104, "R9 silent swap stored");

        // R10: unrecognised command
        issue(3'd7, 112, 3, 64'h1234, '0, 1'b0, 1'b0, v, d, e);
        chk(v && e && d == 0, "R10 bad cmd err", {d[62:0], e}, 1);
        check_word(112, "R10 bad cmd unchanged");

        // R11: back-pressure on the response channel
        @(negedge clk);
        rsp_ready = 1'b0;
        req_cmd = 3'd0; req_addr = AW'(16); req_size = 2'd3; req_need_rsp = 1'b1;
        req_cache_answered = 1'b0; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_cmd = 3'd1; req_addr = AW'(24); req_wdata = 64'hABCD_0123_4567_89EF;
        old = rsp_data;
        chk(rsp_valid && rsp_data == mrd(16, 3), "R11 stalled data", rsp_data, mrd(16, 3));
        chk(!req_ready, "R11 ready low", 64'(req_ready), 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(rsp_valid && rsp_data == old && !rsp_err, "R11 held stable", rsp_data, old);
        chk(!req_ready, "R11 ready still low", 64'(req_ready), 0);
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid && rsp_data == 0, "R11 queued write ack", rsp_data, 0);
        mwr(24, 3, 64'hABCD_0123_4567_89EF);
        check_word(24, "R11 queued write stored");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule